// File: doc/BRIEF.md
# CAN Receive FIFO Filter Matcher

This block decides whether one received CAN frame, held in the receive shift buffer, is accepted by one entry of the receive FIFO filter table. A 2-bit format code selects how the entry is read. The block forms a 32-bit compare key from the frame's identifier, IDE flag and RTR flag. It compares that key bit by bit against the entry's 32-bit filter word. A companion 32-bit mask word says which bits take part.

The format code sets which descriptor fields take part. Codes 0 and 1 compare the identifier, IDE and RTR. Code 2 compares only the identifier, because descriptors of that table format carry no IDE or RTR field. Code 3 rejects every frame, whatever the mask and filter words hold.

The surrounding receive logic presents one frame and one filter entry together with a one-cycle valid strobe. It takes the verdict one clock later, with a result-valid pulse alongside it. Choosing among several entries is left to that surrounding logic.

Top module: `can_rxfifo_flt_match`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it goes high, res_valid and res_match are 0.
- R2: res_valid is 1 in exactly the cycle after a cycle in which cmp_valid was 1 at the clock edge, and 0 otherwise.
- R3: res_match is 0 in every cycle in which res_valid is 0.
- R4: With format code 0 or 1 the compare key is laid out as follows: bit 31 is RTR, bit 30 is IDE, bit 29 is a fixed 0, and bits 28:0 are the identifier field. The frame matches when key and filter word agree on every bit that takes part.
- R5: A filter bit takes part only when its mask bit is 1. Bit 29 never takes part, in any format.
- R6: With format code 2, bits 31 and 30 never take part, whatever their mask bits are. Only the identifier field bits 28:0 are compared under the mask.
- R7: With format code 3, res_match is 0 for every frame, mask and filter word.
- R8: When IDE is 0 the frame carries a standard identifier. Its 11 bits are taken from frame_id[10:0] and placed in key bits 28:18. Key bits 17:0 are 0, and frame_id[28:11] has no effect.
- R9: When IDE is 1 all 29 bits of frame_id form key bits 28:0.
- R10: Strobes on consecutive cycles each produce their own verdict on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Strobe: frame and filter entry are valid this cycle |
| fmt_sel | input | 2 | Filter table format code, 0 to 3 |
| frame_id | input | 29 | Frame identifier (standard IDs in bits 10:0) |
| frame_ide | input | 1 | 1 for an extended identifier, 0 for a standard one |
| frame_rtr | input | 1 | Remote-request flag of the frame |
| flt_word | input | 32 | Filter data word of the entry |
| flt_mask | input | 32 | Mask word; a 1 makes the bit take part |
| res_valid | output | 1 | Pulses one cycle after cmp_valid |
| res_match | output | 1 | Verdict for the strobed frame; 0 when res_valid is 0 |

## Verification
The hardest situations to reach are those where a bit that must be ignored disagrees with the filter while every other bit agrees. Three such cases exist: the RTR bit under format code 2, bit 29, and the upper identifier bits of a standard frame. The stimulus builds an exact match first. It then sets the mask bit of the field in question, flips only that field, and expects the verdict to stay 1. The complementary case flips a field that does take part and expects 0, so that a match stuck at 1 cannot hide.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    typedef enum logic [1:0] {
        FMT_FULL_A  = 2'd0,
        FMT_FULL_B  = 2'd1,
        FMT_ID_ONLY = 2'd2,
        FMT_REJECT  = 2'd3
    } flt_fmt_e;

    typedef struct packed {
        logic valid;
        logic match;
    } res_state_t;

    // Role of one bit position within the 32-bit compare word.
    typedef enum logic [1:0] {
        ROLE_ID   = 2'd0,
        ROLE_PAD  = 2'd1,
        ROLE_FLAG = 2'd2
    } bit_role_e;

endpackage

// File: rtl/flt_key_builder.sv
module flt_key_builder #(
    parameter int ID_W  = 29,
    parameter int STD_W = 11,
    localparam int WORD_W = ID_W + 3
) (
    input  logic [ID_W-1:0]   frame_id,
    input  logic              frame_ide,
    input  logic              frame_rtr,
    output logic [WORD_W-1:0] key
);
    localparam int FILL_W = ID_W - STD_W;

    logic [ID_W-1:0] id_aligned;

    always_comb begin
        if (frame_ide) begin
            id_aligned = frame_id;
        end else begin
            id_aligned = {frame_id[STD_W-1:0], {FILL_W{1'b0}}};
        end
        key = {frame_rtr, frame_ide, 1'b0, id_aligned};
    end

endmodule

// File: rtl/flt_field_mask.sv
module flt_field_mask
    import can_flt_pkg::*;
#(
    parameter int ID_W = 29,
    localparam int WORD_W = ID_W + 3
) (
    input  logic [1:0]        fmt_sel,
    input  logic [WORD_W-1:0] flt_mask,
    output logic [WORD_W-1:0] eff_mask,
    output logic              reject
);
    flt_fmt_e fmt;
    logic     use_id;
    logic     use_flags;

    always_comb begin
        fmt       = flt_fmt_e'(fmt_sel);
        use_id    = (fmt != FMT_REJECT);
        use_flags = (fmt == FMT_FULL_A) || (fmt == FMT_FULL_B);
        reject    = (fmt == FMT_REJECT);
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        localparam bit_role_e ROLE = (b < ID_W)  ? ROLE_ID :
                                     (b == ID_W) ? ROLE_PAD : ROLE_FLAG;
        if (ROLE == ROLE_ID) begin : g_id
            assign eff_mask[b] = flt_mask[b] & use_id;
        end else if (ROLE == ROLE_FLAG) begin : g_flag
            assign eff_mask[b] = flt_mask[b] & use_flags;
        end else begin : g_pad
            logic unused_pad;
            assign unused_pad  = flt_mask[b];
            assign eff_mask[b] = 1'b0;
        end
    end

endmodule

// File: rtl/flt_bit_compare.sv
module flt_bit_compare #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] key,
    input  logic [WORD_W-1:0] flt_word,
    input  logic [WORD_W-1:0] eff_mask,
    input  logic              reject,
    output logic              hit
);
    logic [WORD_W-1:0] miss;

    for (genvar b = 0; b < WORD_W; b++) begin : g_cmp
        assign miss[b] = eff_mask[b] & (key[b] ^ flt_word[b]);
    end

    assign hit = ~(|miss) & ~reject;

endmodule

// File: rtl/can_rxfifo_flt_match.sv
module can_rxfifo_flt_match
    import can_flt_pkg::*;
#(
    parameter int ID_W  = 29,
    parameter int STD_W = 11,
    localparam int WORD_W = ID_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        fmt_sel,
    input  logic [ID_W-1:0]   frame_id,
    input  logic              frame_ide,
    input  logic              frame_rtr,
    input  logic [WORD_W-1:0] flt_word,
    input  logic [WORD_W-1:0] flt_mask,
    output logic              res_valid,
    output logic              res_match
);
    logic [WORD_W-1:0] key;
    logic [WORD_W-1:0] eff_mask;
    logic              reject;
    logic              hit;
    res_state_t        st_d, st_q;

    flt_key_builder #(.ID_W(ID_W), .STD_W(STD_W)) u_key (
        .frame_id  (frame_id),
        .frame_ide (frame_ide),
        .frame_rtr (frame_rtr),
        .key       (key)
    );

    flt_field_mask #(.ID_W(ID_W)) u_mask (
        .fmt_sel  (fmt_sel),
        .flt_mask (flt_mask),
        .eff_mask (eff_mask),
        .reject   (reject)
    );

    flt_bit_compare #(.WORD_W(WORD_W)) u_cmp (
        .key      (key),
        .flt_word (flt_word),
        .eff_mask (eff_mask),
        .reject   (reject),
        .hit      (hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = cmp_valid;
        st_d.match = cmp_valid & hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign res_match = st_q.match;

endmodule

// File: rtl/can_rxfifo_flt_match_chk.sv
module can_rxfifo_flt_match_chk #(
    parameter int ID_W = 29,
    localparam int WORD_W = ID_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic [1:0]        fmt_sel,
    input logic [WORD_W-1:0] flt_mask,
    input logic              res_valid,
    input logic              res_match
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_match));

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> res_valid);

    // R2
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !res_valid);

    // R3
    a_r3_match_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_match);

    // R7
    a_r7_reject_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && fmt_sel == 2'd3) |=> !res_match);

    // R5
    a_r5_empty_mask_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && fmt_sel != 2'd3 && flt_mask == '0) |=> res_match);

endmodule

bind can_rxfifo_flt_match can_rxfifo_flt_match_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .fmt_sel   (fmt_sel),
    .flt_mask  (flt_mask),
    .res_valid (res_valid),
    .res_match (res_match)
);

// File: tb/sim_can_rxfifo_flt_match.sv
module sim_can_rxfifo_flt_match;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [28:0] frame_id = '0;
    logic        frame_ide = 1'b0;
    logic        frame_rtr = 1'b0;
    logic [31:0] flt_word = '0;
    logic [31:0] flt_mask = '0;
    logic        res_valid;
    logic        res_match;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_rxfifo_flt_match u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .fmt_sel(fmt_sel),
        .frame_id(frame_id), .frame_ide(frame_ide), .frame_rtr(frame_rtr),
        .flt_word(flt_word), .flt_mask(flt_mask),
        .res_valid(res_valid), .res_match(res_match)
    );

    localparam logic [28:0] EXT_ID   = 29'h12345678;
    localparam logic [31:0] EXT_WORD = 32'h52345678; // rtr0 ide1 id
    localparam logic [31:0] ALL      = 32'hFFFF_FFFF;
    localparam logic [10:0] STD_ID   = 11'h5A3;
    localparam logic [31:0] STD_WORD = 32'h168C_0000; // 0x5A3 << 18

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Strobe one compare, check the verdict one cycle later, then idle.
    task automatic strobe(input logic [1:0] f, input logic [28:0] id,
                          input logic ide, input logic rtr,
                          input logic [31:0] w, input logic [31:0] m,
                          input logic exp, input string tag);
        @(negedge clk);
        cmp_valid = 1'b1; fmt_sel = f; frame_id = id;
        frame_ide = ide; frame_rtr = rtr; flt_word = w; flt_mask = m;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(res_valid, 1'b1, {tag, " R2 valid"});
        chk(res_match, exp, tag);
        @(negedge clk);
        chk(res_valid, 1'b0, {tag, " R2 idle"});
        chk(res_match, 1'b0, {tag, " R3 idle"});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_valid, 1'b0, "R1 valid in reset");
        chk(res_match, 1'b0, "R1 match in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid, 1'b0, "R1 valid after reset");
    endtask

    task automatic t_full_formats;
        strobe(2'd0, EXT_ID, 1'b1, 1'b0, EXT_WORD, ALL, 1'b1, "R4 R9 fmt0 exact");
        strobe(2'd0, EXT_ID, 1'b1, 1'b1, EXT_WORD, ALL, 1'b0, "R4 fmt0 rtr differs");
        strobe(2'd1, EXT_ID, 1'b1, 1'b0, EXT_WORD, ALL, 1'b1, "R4 fmt1 exact");
        strobe(2'd1, EXT_ID, 1'b0, 1'b0, EXT_WORD, ALL, 1'b0, "R4 fmt1 ide differs");
        strobe(2'd0, EXT_ID ^ 29'h1, 1'b1, 1'b0, EXT_WORD, ALL, 1'b0, "R9 fmt0 id bit0 differs");
    endtask

    task automatic t_mask;
        strobe(2'd0, EXT_ID, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b1, "R5 empty mask");
        strobe(2'd0, EXT_ID, 1'b1, 1'b0, EXT_WORD | 32'h2000_0000, ALL, 1'b1, "R5 bit29 ignored");
        strobe(2'd1, EXT_ID ^ 29'h8, 1'b1, 1'b0, EXT_WORD, ALL & ~32'h8, 1'b1, "R5 masked id bit3");
    endtask

    task automatic t_id_only;
        strobe(2'd2, EXT_ID, 1'b1, 1'b1, EXT_WORD, ALL, 1'b1, "R6 fmt2 rtr ignored");
        strobe(2'd2, EXT_ID, 1'b1, 1'b0, EXT_WORD ^ 32'h4000_0000, ALL, 1'b1, "R6 fmt2 ide ignored");
        strobe(2'd2, EXT_ID ^ 29'h1, 1'b1, 1'b0, EXT_WORD, ALL, 1'b0, "R6 fmt2 id differs");
    endtask

    task automatic t_reject;
        strobe(2'd3, EXT_ID, 1'b1, 1'b0, EXT_WORD, ALL, 1'b0, "R7 fmt3 exact frame");
        strobe(2'd3, EXT_ID, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, "R7 fmt3 empty mask");
    endtask

    task automatic t_standard;
        strobe(2'd0, {18'h0, STD_ID}, 1'b0, 1'b0, STD_WORD, ALL, 1'b1, "R8 std exact");
        strobe(2'd0, {18'h3FFFF, STD_ID}, 1'b0, 1'b0, STD_WORD, ALL, 1'b1, "R8 std upper bits ignored");
        strobe(2'd0, {18'h0, STD_ID}, 1'b0, 1'b0, STD_WORD | 32'h1, ALL, 1'b0, "R8 std low key bits zero");
        strobe(2'd2, {18'h0, STD_ID ^ 11'h400}, 1'b0, 1'b0, STD_WORD, ALL, 1'b0, "R8 std msb differs");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        cmp_valid = 1'b1; fmt_sel = 2'd0; frame_id = EXT_ID;
        frame_ide = 1'b1; frame_rtr = 1'b0; flt_word = EXT_WORD; flt_mask = ALL;
        @(negedge clk);
        chk(res_valid, 1'b1, "R10 first valid");
        chk(res_match, 1'b1, "R10 first match");
        frame_rtr = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(res_valid, 1'b1, "R10 second valid");
        chk(res_match, 1'b0, "R10 second miss");
        @(negedge clk);
        chk(res_valid, 1'b0, "R10 R2 idle after pair");
    endtask

    initial begin
        t_reset();
        t_full_formats();
        t_mask();
        t_id_only();
        t_reject();
        t_standard();
        t_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule